// File: doc/BRIEF.md
# Power Mode Sequencer

This block sequences a small processor core through four operating modes: two run modes (normal and slow), a low-power idle mode (green) and a power-down mode (sleep). Software selects the target mode with a two-bit mode field and a clock-select bit, written together through one write strobe. In the idle and power-down modes the block also watches wake inputs from two I/O port groups and timeout pulses from two timers.

The block decodes the current mode into enables for the rest of the chip. These are the high-speed and low-speed oscillator enables, the CPU clock enable, the watchdog enable, the gated enables for three timers, and enables for external interrupts, the TC0 timer interrupt and the other internal interrupts. A wake from idle returns to whichever run mode was active before idle was entered, so the block keeps one bit of saved run mode.

All inputs are sampled as levels on the rising edge of the low-speed clock that drives `clk`. Every enable is a decode of the registered mode together with the software bits.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While reset is asserted and after it is released, `mode` is 00 (normal), the saved run mode is normal, and the oscillators, CPU clock and watchdog are enabled.
- R2: `mode` encodes the state as 00 normal, 01 slow, 10 green and 11 sleep. In normal or slow mode, a write with `cfg_cpum`=01 gives sleep on the next cycle and `cfg_cpum`=10 gives green. Any other `cfg_cpum` value gives slow when `cfg_slow`=1 and normal when `cfg_slow`=0.
- R3: Entering green saves the run mode that was current before the write. A wake from green returns to that saved mode, even if the entering write also changed `cfg_slow`.
- R4: Green wakes on the next edge when any of `wake_p0`, `wake_p1`, `t0_tmo` or `tc0_tmo` is high. With none of them high, it stays in green.
- R5: Sleep wakes to normal only when `wake_p0` or `wake_p1` is high. The two timer timeouts leave sleep unchanged.
- R6: Writes are ignored in green and sleep, including writes made in the cycle of a wake. Wake inputs are ignored in normal and slow.
- R7: `ls_osc_en` is high in every mode except sleep. `hs_osc_en` is high in normal, equals the inverse of `hs_stop` in slow and green, and is low in sleep.
- R8: `cpu_clk_en` and `wdt_en` are high only in normal and slow.
- R9: `t0_en` and `tc0_en` follow their software enables in every mode except sleep, where they are low. `tc1_en` follows its software enable only in normal and slow.
- R10: `irq_ext_en` and `irq_tc0_en` are high in every mode except sleep. `irq_int_en` (the other internal interrupts) is high only in normal and slow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the mode field and clock-select bit |
| cfg_cpum | input | 2 | Mode field: 01 sleep, 10 green, otherwise run |
| cfg_slow | input | 1 | Run-mode select: 0 normal, 1 slow |
| hs_stop | input | 1 | Software stop for the high-speed oscillator in slow and green |
| t0_sw_en | input | 1 | Software enable for timer T0 |
| tc0_sw_en | input | 1 | Software enable for timer TC0 |
| tc1_sw_en | input | 1 | Software enable for timer TC1 |
| wake_p0 | input | 1 | Wake request from port group 0 |
| wake_p1 | input | 1 | Wake request from port group 1 |
| t0_tmo | input | 1 | Timer T0 timeout |
| tc0_tmo | input | 1 | Timer TC0 timeout |
| mode | output | 2 | Current mode (00 normal, 01 slow, 10 green, 11 sleep) |
| ls_osc_en | output | 1 | Low-speed oscillator enable |
| hs_osc_en | output | 1 | High-speed oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| wdt_en | output | 1 | Watchdog enable |
| t0_en | output | 1 | Gated T0 enable |
| tc0_en | output | 1 | Gated TC0 enable |
| tc1_en | output | 1 | Gated TC1 enable |
| irq_ext_en | output | 1 | External interrupt enable |
| irq_tc0_en | output | 1 | TC0 interrupt enable |
| irq_int_en | output | 1 | Enable for internal interrupts other than TC0 |

## Verification
A write or wake that is present at a rising edge moves `mode` at that same edge, so the new mode is due one cycle after the stimulus. Every enable is a combinational decode of `mode` and the software bits, so it is due in the same cycle as `mode`. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. At that point it compares `mode` and all ten enables with a reference model that is stepped once per edge. It sweeps every starting state against all sixteen wake patterns and every write value, and it varies the software bits at the same time.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_cpum,
  input  logic       cfg_slow,
  input  logic       hs_stop,
  input  logic       t0_sw_en,
  input  logic       tc0_sw_en,
  input  logic       tc1_sw_en,
  input  logic       wake_p0,
  input  logic       wake_p1,
  input  logic       t0_tmo,
  input  logic       tc0_tmo,
  output logic [1:0] mode,
  output logic       ls_osc_en,
  output logic       hs_osc_en,
  output logic       cpu_clk_en,
  output logic       wdt_en,
  output logic       t0_en,
  output logic       tc0_en,
  output logic       tc1_en,
  output logic       irq_ext_en,
  output logic       irq_tc0_en,
  output logic       irq_int_en
);
  localparam logic [1:0] M_NORM  = 2'b00;
  localparam logic [1:0] M_SLOW  = 2'b01;
  localparam logic [1:0] M_GREEN = 2'b10;
  localparam logic [1:0] M_SLEEP = 2'b11;

  logic [1:0] mode_q, mode_d;
  logic       saved_slow_q, saved_slow_d;

  wire port_wake = wake_p0 | wake_p1;
  wire idle_wake = port_wake | t0_tmo | tc0_tmo;
  wire running   = (mode_q == M_NORM) | (mode_q == M_SLOW);
  wire awake     = (mode_q != M_SLEEP);

  always_comb begin
    mode_d       = mode_q;
    saved_slow_d = saved_slow_q;
    unique case (mode_q)
      M_NORM, M_SLOW: if (cfg_we) begin
        unique case (cfg_cpum)
          2'b01: mode_d = M_SLEEP;
          2'b10: begin
            mode_d       = M_GREEN;
            saved_slow_d = (mode_q == M_SLOW);
          end
          default: mode_d = cfg_slow ? M_SLOW : M_NORM;
        endcase
      end
      M_GREEN: if (idle_wake) mode_d = saved_slow_q ? M_SLOW : M_NORM;
      M_SLEEP: if (port_wake) begin
        mode_d       = M_NORM;
        saved_slow_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= M_NORM;
      saved_slow_q <= 1'b0;
    end else begin
      mode_q       <= mode_d;
      saved_slow_q <= saved_slow_d;
    end
  end

  assign mode       = mode_q;
  assign ls_osc_en  = awake;
  assign hs_osc_en  = (mode_q == M_NORM) | (awake & ~hs_stop);
  assign cpu_clk_en = running;
  assign wdt_en     = running;
  assign t0_en      = t0_sw_en & awake;
  assign tc0_en     = tc0_sw_en & awake;
  assign tc1_en     = tc1_sw_en & running;
  assign irq_ext_en = awake;
  assign irq_tc0_en = awake;
  assign irq_int_en = running;
endmodule

module pwr_mode_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [1:0] cfg_cpum,
  input logic       wake_p0,
  input logic       wake_p1,
  input logic       t0_tmo,
  input logic       tc0_tmo,
  input logic [1:0] mode,
  input logic       ls_osc_en,
  input logic       hs_osc_en,
  input logic       cpu_clk_en,
  input logic       wdt_en,
  input logic       tc1_en,
  input logic       irq_int_en
);
  a_r2_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] == 1'b0 && cfg_we && cfg_cpum == 2'b01) |=> mode == 2'b11);
  a_r2_green_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] == 1'b0 && cfg_we && cfg_cpum == 2'b10) |=> mode == 2'b10);
  a_r4_green_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && (wake_p0 || wake_p1 || t0_tmo || tc0_tmo)) |=> mode[1] == 1'b0);
  a_r5_sleep_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && (wake_p0 || wake_p1)) |=> mode == 2'b00);
  a_r6_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && !wake_p0 && !wake_p1) |=> $stable(mode));
  a_r7_sleep_osc_off: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |-> (!ls_osc_en && !hs_osc_en));
  a_r8_green_cpu_off: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |-> (!cpu_clk_en && !wdt_en && !tc1_en && !irq_int_en));
endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cpum(cfg_cpum),
  .wake_p0(wake_p0), .wake_p1(wake_p1), .t0_tmo(t0_tmo), .tc0_tmo(tc0_tmo),
  .mode(mode), .ls_osc_en(ls_osc_en), .hs_osc_en(hs_osc_en),
  .cpu_clk_en(cpu_clk_en), .wdt_en(wdt_en), .tc1_en(tc1_en),
  .irq_int_en(irq_int_en)
);

// File: tb/sim_pwr_mode_ctl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_slow = 1'b0, hs_stop = 1'b0;
  logic [1:0] cfg_cpum = 2'b00;
  logic t0_sw_en = 1'b0, tc0_sw_en = 1'b0, tc1_sw_en = 1'b0;
  logic wake_p0 = 1'b0, wake_p1 = 1'b0, t0_tmo = 1'b0, tc0_tmo = 1'b0;
  logic [1:0] mode;
  logic ls_osc_en, hs_osc_en, cpu_clk_en, wdt_en, t0_en, tc0_en, tc1_en;
  logic irq_ext_en, irq_tc0_en, irq_int_en;

  int checks = 0, failures = 0;
  logic [1:0] em;
  logic es;

  always #2.5 clk = ~clk;

  pwr_mode_ctl u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d mode=%0d", req, act, exp, em);
    end
  endtask

  task automatic check_all();
    logic run, awk;
    run = (em == 2'b00) || (em == 2'b01);
    awk = (em != 2'b11);
    chk("R2 mode", mode, em);
    chk("R7 ls_osc", ls_osc_en, awk);
    chk("R7 hs_osc", hs_osc_en, (em == 2'b00) ? 1 : (awk ? !hs_stop : 0));
    chk("R8 cpu_clk", cpu_clk_en, run);
    chk("R8 wdt", wdt_en, run);
    chk("R9 t0", t0_en, t0_sw_en && awk);
    chk("R9 tc0", tc0_en, tc0_sw_en && awk);
    chk("R9 tc1", tc1_en, tc1_sw_en && run);
    chk("R10 ext", irq_ext_en, awk);
    chk("R10 tc0", irq_tc0_en, awk);
    chk("R10 int", irq_int_en, run);
  endtask

  task automatic model_step();
    case (em)
      2'b00, 2'b01: if (cfg_we) begin
        if (cfg_cpum == 2'b01) em = 2'b11;
        else if (cfg_cpum == 2'b10) begin es = (em == 2'b01); em = 2'b10; end
        else em = cfg_slow ? 2'b01 : 2'b00;
      end
      2'b10: if (wake_p0 | wake_p1 | t0_tmo | tc0_tmo) em = es ? 2'b01 : 2'b00;
      default: if (wake_p0 | wake_p1) begin em = 2'b00; es = 1'b0; end
    endcase
  endtask

  task automatic step(input logic we, input logic [1:0] cp, input logic sl,
                      input logic [3:0] wk, input logic [3:0] sw);
    @(negedge clk);
    cfg_we = we; cfg_cpum = cp; cfg_slow = sl;
    {wake_p0, wake_p1, t0_tmo, tc0_tmo} = wk;
    {hs_stop, t0_sw_en, tc0_sw_en, tc1_sw_en} = sw;
    @(posedge clk);
    model_step();
    #1;
    check_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_we = 1'b0;
    {wake_p0, wake_p1, t0_tmo, tc0_tmo} = 4'b0;
    em = 2'b00; es = 1'b0;
    #1;
    chk("R1 mode in reset", mode, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 mode after reset", mode, 0);
    chk("R1 hs_osc", hs_osc_en, 1);
    chk("R1 cpu_clk", cpu_clk_en, 1);
  endtask

  // start states: 0 normal, 1 slow, 2 green from normal, 3 green from slow, 4 sleep
  task automatic go_start(input int s, input logic [3:0] sw);
    do_reset();
    case (s)
      1: step(1, 2'b00, 1, 4'b0, sw);
      2: step(1, 2'b10, 1, 4'b0, sw);
      3: begin step(1, 2'b00, 1, 4'b0, sw); step(1, 2'b10, 0, 4'b0, sw); end
      4: step(1, 2'b01, 0, 4'b0, sw);
      default: ;
    endcase
  endtask

  initial begin
    em = 2'b00; es = 1'b0;
    for (int s = 0; s < 5; s++)
      for (int wk = 0; wk < 16; wk++)
        for (int w = 0; w < 8; w++) begin
          logic [3:0] sw;
          sw = 4'((s * 7 + wk * 3 + w) & 15);
          go_start(s, sw);
          // R6 R4 R5 R3: write and wake pattern together
          step(1, 2'(w >> 1), w[0], 4'(wk), sw);
          // R3 follow-up: idle a cycle, then wake via port 0
          step(0, 2'b00, 0, 4'b0, ~sw);
          step(0, 2'b00, 0, 4'b1000, sw);
        end
    // R5: timer timeouts alone do not wake sleep
    go_start(4, 4'b1111);
    step(0, 2'b00, 0, 4'b0011, 4'b1111);
    chk("R5 sleep ignores timeouts", mode, 3);
    step(0, 2'b00, 0, 4'b0100, 4'b1111);
    chk("R5 port1 wakes sleep", mode, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule